// File: doc/BRIEF.md
# Windowed Memory-Operation Issue Queue

This block holds the memory operations of an out-of-order core in a circular queue, filled in program order at the tail and drained at the head. Each entry moves from waiting for its operands, to ready, to issued. Every cycle the queue offers at most one ready entry to the data-cache port, always the oldest one that is eligible. The port accepts it with a grant, and the entry is then marked issued. Retirement frees the head entry once that entry has been issued. A flush empties the whole queue.

Eligibility is limited by a sliding window. A virtual head marks the oldest entry not yet issued, and only entries less than `WIN_SIZE` positions past it may be offered. The virtual head stays where it is while younger entries inside the window issue. When its own entry issues, it jumps forward over every consecutive issued entry to the next unissued one, or to the tail if none is left. The window limits how far loads and stores can overtake each other. A size of 1 gives strictly in-order memory issue. A size of 0, or any size of at least the queue depth, turns the block into a plain queue that offers any ready entry. The size is fixed when the block is built.

Top module: `memq_window_issue`

## Requirements
- R1: Reset and `flush` put head, tail and virtual head at 0, return every entry to waiting, and leave `sel_valid` low in the following cycle.
- R2: An allocation writes the entry at `tail_ptr` and advances the tail by one. An allocation made while the queue holds `DEPTH` entries is ignored. Pointers are `$clog2(DEPTH)+1` bits wide, the top bit being a wrap flag, so occupancy is `tail_ptr - head_ptr`.
- R3: A mark on `mark_idx` turns a waiting entry ready. A mark on a ready or issued entry has no effect. An allocation with `alloc_rdy` high creates the entry already ready. Waiting entries are never offered.
- R4: Among eligible ready entries, the one nearest the head in program order is offered on `sel_idx`, together with its tag, store flag and size. When `issue_grant` is high with `sel_valid`, that entry becomes issued at the clock edge.
- R5: In unlimited mode (`WIN_SIZE` 0, or at least `DEPTH`) every ready entry in the queue is eligible, whatever its position.
- R6: In windowed mode only entries whose distance past the virtual head, modulo `DEPTH`, is below `WIN_SIZE` are eligible.
- R7: The virtual head moves only when its own entry issues. It then skips every following consecutive issued entry and stops at the oldest unissued entry, or at the tail if there is none.
- R8: With `WIN_SIZE` 1, only the entry at the virtual head can be offered, so memory issue is strictly in order.
- R9: `retire` frees the head entry and advances the head only if that entry is issued. Otherwise it is ignored.
- R10: The virtual head never lies behind the head or beyond the tail.
- R11: `vtail_ptr` equals virtual head plus `WIN_SIZE` in windowed mode, and equals `tail_ptr` in unlimited mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue |
| alloc_valid | input | 1 | Append an operation at the tail |
| alloc_rdy | input | 1 | New operation already has its operands |
| alloc_store | input | 1 | New operation is a store (1) or load (0) |
| alloc_size | input | 2 | Access size code of the new operation |
| alloc_tag | input | TAG_W | Tag of the new operation |
| mark_valid | input | 1 | Operand-ready mark strobe |
| mark_idx | input | $clog2(DEPTH) | Entry receiving the mark |
| issue_grant | input | 1 | Cache port accepts the offered entry |
| retire | input | 1 | Request to free the head entry |
| sel_valid | output | 1 | An entry is offered |
| sel_idx | output | $clog2(DEPTH) | Index of the offered entry |
| sel_tag | output | TAG_W | Tag of the offered entry |
| sel_store | output | 1 | Store flag of the offered entry |
| sel_size | output | 2 | Size code of the offered entry |
| head_ptr | output | $clog2(DEPTH)+1 | Queue head with wrap flag |
| tail_ptr | output | $clog2(DEPTH)+1 | Queue tail with wrap flag |
| vhead_ptr | output | $clog2(DEPTH)+1 | Window start (oldest unissued) |
| vtail_ptr | output | $clog2(DEPTH)+1 | Window end, exclusive |

## Verification
The assertions assume that the environment raises `retire` no faster than the cycle after an issue can be seen, and that a mark names an entry index below `DEPTH`. Both hold at the ports: an early retire is dropped and the index is only `$clog2(DEPTH)` bits wide. The stall check on the virtual head relies on the rule that every entry in front of it has already issued. The stimulus therefore reaches issued state only through grants on offered entries, never by writing entries directly. Three builds with windows of 4, 1 and unlimited receive the same directed and random traffic, including allocations into a full queue and marks on issued entries. A model of the queue predicts every output of each build from the requirements.

// File: rtl/memq_pkg.sv
package memq_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_RDY  = 2'd1,
      ST_DONE = 2'd2
   } mq_state_e;

   localparam int SIZE_W = 2;

endpackage

// File: rtl/memq_entry_array.sv
module memq_entry_array
   import memq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc_we,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic              alloc_rdy,
   input  logic              alloc_store,
   input  logic [SIZE_W-1:0] alloc_size,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              mark_we,
   input  logic [IDX_W-1:0]  mark_idx,
   input  logic              iss_we,
   input  logic [IDX_W-1:0]  iss_idx,
   input  logic              ret_we,
   input  logic [IDX_W-1:0]  ret_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   output mq_state_e         st_q [DEPTH],
   output mq_state_e         st_d [DEPTH],
   output logic [TAG_W-1:0]  rd_tag,
   output logic              rd_store,
   output logic [SIZE_W-1:0] rd_size
);

   logic [TAG_W-1:0]  tag_q   [DEPTH];
   logic              store_q [DEPTH];
   logic [SIZE_W-1:0] size_q  [DEPTH];

   // priority per entry: allocate, retire, issue, operand mark
   always_comb begin
      for (int e = 0; e < DEPTH; e++) begin
         st_d[e] = st_q[e];
         if (alloc_we && alloc_idx == IDX_W'(e))
            st_d[e] = alloc_rdy ? ST_RDY : ST_WAIT;
         else if (ret_we && ret_idx == IDX_W'(e))
            st_d[e] = ST_WAIT;
         else if (iss_we && iss_idx == IDX_W'(e))
            st_d[e] = ST_DONE;
         else if (mark_we && mark_idx == IDX_W'(e) && st_q[e] == ST_WAIT)
            st_d[e] = ST_RDY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) st_q[e] <= ST_WAIT;
      end else if (flush) begin
         for (int e = 0; e < DEPTH; e++) st_q[e] <= ST_WAIT;
      end else begin
         for (int e = 0; e < DEPTH; e++) st_q[e] <= st_d[e];
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (alloc_we && alloc_idx == IDX_W'(e)) begin
            tag_q[e]   <= alloc_tag;
            store_q[e] <= alloc_store;
            size_q[e]  <= alloc_size;
         end
      end
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_store = store_q[rd_idx];
   assign rd_size  = size_q[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R3: an issued entry ignores marks and keeps its state until freed
      a_r3_issued_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[g] == ST_DONE && !flush && !(ret_we && ret_idx == IDX_W'(g))
          && !(alloc_we && alloc_idx == IDX_W'(g)))
         |=> st_q[g] == ST_DONE);
   end

endmodule

// File: rtl/memq_oldest_pick.sv
module memq_oldest_pick
   import memq_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  mq_state_e         st_q [DEPTH],
   input  logic [DEPTH-1:0]  win_mask,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic [PTR_W-1:0]  count,
   output logic              sel_valid,
   output logic [IDX_W-1:0]  sel_idx
);

   logic [IDX_W-1:0] idx;

   // scan from youngest to oldest so the oldest hit is written last
   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      idx       = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         idx = head_idx + IDX_W'(k);
         if (PTR_W'(k) < count && st_q[idx] == ST_RDY && win_mask[idx]) begin
            sel_valid = 1'b1;
            sel_idx   = idx;
         end
      end
   end

endmodule

// File: rtl/memq_vhead_scan.sv
module memq_vhead_scan
   import memq_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  mq_state_e         st_d [DEPTH],
   input  logic [PTR_W-1:0]  vh_q,
   input  logic [PTR_W-1:0]  tail_d,
   output logic [PTR_W-1:0]  vh_d
);

   logic [PTR_W-1:0] pos;
   logic             found;

   always_comb begin
      vh_d  = tail_d;
      found = 1'b0;
      pos   = vh_q;
      for (int k = 0; k < DEPTH; k++) begin
         pos = vh_q + PTR_W'(k);
         if (!found) begin
            if (pos == tail_d) begin
               found = 1'b1;
            end else if (st_d[pos[IDX_W-1:0]] != ST_DONE) begin
               vh_d  = pos;
               found = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/memq_window_issue.sv
module memq_window_issue
   import memq_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int TAG_W    = 4,
   parameter int WIN_SIZE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     alloc_valid,
   input  logic                     alloc_rdy,
   input  logic                     alloc_store,
   input  logic [1:0]               alloc_size,
   input  logic [TAG_W-1:0]         alloc_tag,
   input  logic                     mark_valid,
   input  logic [$clog2(DEPTH)-1:0] mark_idx,
   input  logic                     issue_grant,
   input  logic                     retire,
   output logic                     sel_valid,
   output logic [$clog2(DEPTH)-1:0] sel_idx,
   output logic [TAG_W-1:0]         sel_tag,
   output logic                     sel_store,
   output logic [1:0]               sel_size,
   output logic [$clog2(DEPTH):0]   head_ptr,
   output logic [$clog2(DEPTH):0]   tail_ptr,
   output logic [$clog2(DEPTH):0]   vhead_ptr,
   output logic [$clog2(DEPTH):0]   vtail_ptr
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int PTR_W = IDX_W + 1;
   localparam bit UNLIM = (WIN_SIZE == 0) || (WIN_SIZE >= DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("memq_window_issue: DEPTH must be a power of two, at least 2");
   end
   if (WIN_SIZE < 0) begin : g_bad_win
      $error("memq_window_issue: WIN_SIZE must not be negative");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("memq_window_issue: TAG_W must be at least 1");
   end

   logic [PTR_W-1:0] head_q, tail_q, vh_q;
   logic [PTR_W-1:0] head_d, tail_d, vh_scan;
   logic [PTR_W-1:0] count;
   logic             full, alloc_ok, ret_ok, fire;
   logic [DEPTH-1:0] win_mask;
   mq_state_e        st_q [DEPTH];
   mq_state_e        st_d [DEPTH];

   assign count    = tail_q - head_q;
   assign full     = (count == PTR_W'(DEPTH));
   assign alloc_ok = alloc_valid && !full;
   assign ret_ok   = retire && (count != '0) && (st_q[head_q[IDX_W-1:0]] == ST_DONE);
   assign fire     = issue_grant && sel_valid;
   assign head_d   = head_q + PTR_W'(ret_ok);
   assign tail_d   = tail_q + PTR_W'(alloc_ok);

   memq_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_entries (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .alloc_we    (alloc_ok),
      .alloc_idx   (tail_q[IDX_W-1:0]),
      .alloc_rdy   (alloc_rdy),
      .alloc_store (alloc_store),
      .alloc_size  (alloc_size),
      .alloc_tag   (alloc_tag),
      .mark_we     (mark_valid),
      .mark_idx    (mark_idx),
      .iss_we      (fire),
      .iss_idx     (sel_idx),
      .ret_we      (ret_ok),
      .ret_idx     (head_q[IDX_W-1:0]),
      .rd_idx      (sel_idx),
      .st_q        (st_q),
      .st_d        (st_d),
      .rd_tag      (sel_tag),
      .rd_store    (sel_store),
      .rd_size     (sel_size)
   );

   memq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
      .st_q      (st_q),
      .win_mask  (win_mask),
      .head_idx  (head_q[IDX_W-1:0]),
      .count     (count),
      .sel_valid (sel_valid),
      .sel_idx   (sel_idx)
   );

   memq_vhead_scan #(.DEPTH(DEPTH)) u_scan (
      .st_d   (st_d),
      .vh_q   (vh_q),
      .tail_d (tail_d),
      .vh_d   (vh_scan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         vh_q   <= '0;
      end else if (flush) begin
         head_q <= '0;
         tail_q <= '0;
         vh_q   <= '0;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
         vh_q   <= vh_scan;
      end
   end

   assign head_ptr  = head_q;
   assign tail_ptr  = tail_q;
   assign vhead_ptr = vh_q;

   if (UNLIM) begin : g_unlim
      assign win_mask  = '1;
      assign vtail_ptr = tail_q;
   end else begin : g_win
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [IDX_W-1:0] dist_g;
         assign dist_g      = IDX_W'(g) - vh_q[IDX_W-1:0];
         assign win_mask[g] = (dist_g < IDX_W'(WIN_SIZE));
      end
      assign vtail_ptr = vh_q + PTR_W'(WIN_SIZE);

      // R6: the offered entry lies inside the window
      a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
         sel_valid |-> (IDX_W'(sel_idx - vh_q[IDX_W-1:0]) < IDX_W'(WIN_SIZE)));

      if (WIN_SIZE == 1) begin : g_inorder
         // R8: only the oldest unissued entry can be offered
         a_r8_in_order: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid |-> sel_idx == vh_q[IDX_W-1:0]);
      end
   end

   // R4: the offered entry is ready
   a_r4_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> st_q[sel_idx] == ST_RDY);

   // R2: occupancy never exceeds the depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PTR_W'(DEPTH));

   // R7: the virtual head holds while its entry stays unissued
   a_r7_vhead_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && vh_q != tail_q && !(fire && sel_idx == vh_q[IDX_W-1:0]))
      |=> $stable(vh_q));

   // R9: the head advances only over an issued entry
   a_r9_retire_issued: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(head_q) && !$past(flush)) |-> $past(st_q[head_q[IDX_W-1:0]]) == ST_DONE);

   // R10: head <= virtual head <= tail
   a_r10_vhead_order: assert property (@(posedge clk) disable iff (!rst_n)
      PTR_W'(vh_q - head_q) <= count);

   // R1: a flush leaves nothing to offer
   a_r1_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !sel_valid && tail_q == '0);

endmodule

// File: tb/memq_window_issue_bench.sv
`timescale 1ns/100ps
module memq_window_issue_bench;

   localparam int NI = 3;
   localparam int WINS [NI] = '{4, 1, 0};
   localparam string SELREQ [NI] = '{"R6", "R8", "R5"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0, alloc_valid = 1'b0, alloc_rdy = 1'b0, alloc_store = 1'b0;
   logic [1:0] alloc_size = '0;
   logic [3:0] alloc_tag = '0;
   logic mark_valid = 1'b0;
   logic [2:0] mark_idx = '0;
   logic issue_grant = 1'b0, retire = 1'b0;

   logic       o_sv [NI];
   logic [2:0] o_si [NI];
   logic [3:0] o_tg [NI];
   logic       o_st [NI];
   logic [1:0] o_sz [NI];
   logic [3:0] o_hd [NI], o_tl [NI], o_vh [NI], o_vt [NI];

   int n_chk = 0, n_bad = 0;
   int m_st [NI][8], m_tag [NI][8], m_str [NI][8], m_sz [NI][8];
   int m_hd [NI], m_tl [NI], m_vh [NI];
   int tg = 1;

   always #2.5 clk = ~clk;

   memq_window_issue #(.DEPTH(8), .TAG_W(4), .WIN_SIZE(4)) u_memq_window_issue (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
      .alloc_rdy(alloc_rdy), .alloc_store(alloc_store), .alloc_size(alloc_size),
      .alloc_tag(alloc_tag), .mark_valid(mark_valid), .mark_idx(mark_idx),
      .issue_grant(issue_grant), .retire(retire), .sel_valid(o_sv[0]),
      .sel_idx(o_si[0]), .sel_tag(o_tg[0]), .sel_store(o_st[0]), .sel_size(o_sz[0]),
      .head_ptr(o_hd[0]), .tail_ptr(o_tl[0]), .vhead_ptr(o_vh[0]), .vtail_ptr(o_vt[0]));

   memq_window_issue #(.DEPTH(8), .TAG_W(4), .WIN_SIZE(1)) u_memq_window_issue_w1 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
      .alloc_rdy(alloc_rdy), .alloc_store(alloc_store), .alloc_size(alloc_size),
      .alloc_tag(alloc_tag), .mark_valid(mark_valid), .mark_idx(mark_idx),
      .issue_grant(issue_grant), .retire(retire), .sel_valid(o_sv[1]),
      .sel_idx(o_si[1]), .sel_tag(o_tg[1]), .sel_store(o_st[1]), .sel_size(o_sz[1]),
      .head_ptr(o_hd[1]), .tail_ptr(o_tl[1]), .vhead_ptr(o_vh[1]), .vtail_ptr(o_vt[1]));

   memq_window_issue #(.DEPTH(8), .TAG_W(4), .WIN_SIZE(0)) u_memq_window_issue_inf (
      .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
      .alloc_rdy(alloc_rdy), .alloc_store(alloc_store), .alloc_size(alloc_size),
      .alloc_tag(alloc_tag), .mark_valid(mark_valid), .mark_idx(mark_idx),
      .issue_grant(issue_grant), .retire(retire), .sel_valid(o_sv[2]),
      .sel_idx(o_si[2]), .sel_tag(o_tg[2]), .sel_store(o_st[2]), .sel_size(o_sz[2]),
      .head_ptr(o_hd[2]), .tail_ptr(o_tl[2]), .vhead_ptr(o_vh[2]), .vtail_ptr(o_vt[2]));

   task automatic chk(string req, int c, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s inst%0d %s actual=%0d expected=%0d", req, c, what, act, exp);
      end
   endtask

   // oldest ready entry in queue order that the window admits; -1 if none
   function automatic int pick(int c);
      int cnt;
      cnt = (m_tl[c] - m_hd[c]) & 15;
      for (int k = 0; k < cnt; k++) begin
         int i;
         i = (m_hd[c] + k) & 7;
         if (m_st[c][i] == 1 && (WINS[c] == 0 || ((i - m_vh[c]) & 7) < WINS[c]))
            return i;
      end
      return -1;
   endfunction

   task automatic model_clear();
      for (int c = 0; c < NI; c++) begin
         for (int e = 0; e < 8; e++) m_st[c][e] = 0;
         m_hd[c] = 0; m_tl[c] = 0; m_vh[c] = 0;
      end
   endtask

   task automatic model_step(int c);
      int p, cnt, nt, v;
      int ns [8];
      if (flush) begin
         for (int e = 0; e < 8; e++) m_st[c][e] = 0;
         m_hd[c] = 0; m_tl[c] = 0; m_vh[c] = 0;
         return;
      end
      p   = pick(c);
      cnt = (m_tl[c] - m_hd[c]) & 15;
      nt  = m_tl[c];
      for (int e = 0; e < 8; e++) ns[e] = m_st[c][e];
      if (mark_valid && m_st[c][mark_idx] == 0) ns[mark_idx] = 1;
      if (issue_grant && p >= 0) ns[p] = 2;
      if (retire && cnt > 0 && m_st[c][m_hd[c] & 7] == 2) begin
         ns[m_hd[c] & 7] = 0;
         m_hd[c] = (m_hd[c] + 1) & 15;
      end
      if (alloc_valid && cnt < 8) begin
         ns[m_tl[c] & 7] = alloc_rdy ? 1 : 0;
         m_tag[c][m_tl[c] & 7] = alloc_tag;
         m_str[c][m_tl[c] & 7] = alloc_store;
         m_sz[c][m_tl[c] & 7]  = alloc_size;
         nt = (m_tl[c] + 1) & 15;
      end
      m_tl[c] = nt;
      for (int e = 0; e < 8; e++) m_st[c][e] = ns[e];
      v = m_vh[c];
      while (v != nt && ns[v & 7] == 2) v = (v + 1) & 15;
      m_vh[c] = v;
   endtask

   task automatic compare_all();
      for (int c = 0; c < NI; c++) begin
         int p, vt;
         p = pick(c);
         chk(SELREQ[c], c, "sel_valid", int'(o_sv[c]), (p >= 0) ? 1 : 0);
         if (p >= 0 && o_sv[c]) begin
            chk("R4", c, "sel_idx", int'(o_si[c]), p);
            chk("R4", c, "sel_tag", int'(o_tg[c]), m_tag[c][p]);
            chk("R4", c, "sel_store", int'(o_st[c]), m_str[c][p]);
            chk("R4", c, "sel_size", int'(o_sz[c]), m_sz[c][p]);
         end
         chk("R9", c, "head_ptr", int'(o_hd[c]), m_hd[c]);
         chk("R2", c, "tail_ptr", int'(o_tl[c]), m_tl[c]);
         chk("R7", c, "vhead_ptr", int'(o_vh[c]), m_vh[c]);
         vt = (WINS[c] == 0) ? m_tl[c] : ((m_vh[c] + WINS[c]) & 15);
         chk("R11", c, "vtail_ptr", int'(o_vt[c]), vt);
         chk("R10", c, "vhead_order",
             (((o_vh[c] - o_hd[c]) & 15) <= ((o_tl[c] - o_hd[c]) & 15)) ? 1 : 0, 1);
      end
   endtask

   // drive one cycle at the falling edge, step the model, compare after the next rise
   task automatic cyc(bit av, bit ar, bit mv, int mi, bit g, bit r, bit f);
      alloc_valid = av; alloc_rdy = ar;
      alloc_tag = 4'(tg); alloc_store = tg[0]; alloc_size = 2'(tg >> 1);
      if (av) tg++;
      mark_valid = mv; mark_idx = 3'(mi);
      issue_grant = g; retire = r; flush = f;
      for (int c = 0; c < NI; c++) model_step(c);
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int c = 0; c < NI; c++) begin
         chk("R1", c, "reset head", int'(o_hd[c]), 0);
         chk("R1", c, "reset tail", int'(o_tl[c]), 0);
         chk("R1", c, "reset sel_valid", int'(o_sv[c]), 0);
      end
      compare_all();

      repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R3", 0, "waiting not offered", int'(o_sv[0]), 0);
      cyc(0, 0, 1, 2, 0, 0, 0);
      chk("R6", 0, "entry 2 inside window", int'(o_si[0]), 2);
      chk("R8", 1, "entry 2 outside size-1 window", int'(o_sv[1]), 0);
      chk("R5", 2, "unlimited offers entry 2", int'(o_si[2]), 2);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk("R7", 0, "younger issue keeps vhead", int'(o_vh[0]), 0);
      cyc(0, 0, 1, 2, 0, 0, 0);
      chk("R3", 0, "mark on issued ignored", int'(o_sv[0]), 0);
      cyc(0, 0, 1, 0, 0, 0, 0);
      cyc(0, 0, 1, 1, 0, 0, 0);
      chk("R4", 2, "oldest of 0,1 chosen", int'(o_si[2]), 0);
      chk("R8", 1, "vhead entry chosen", int'(o_si[1]), 0);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk("R7", 0, "vhead to oldest unissued", int'(o_vh[0]), 1);
      chk("R11", 0, "vtail vhead+4", int'(o_vt[0]), 5);
      chk("R11", 2, "vtail equals tail", int'(o_vt[2]), 3);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk("R7", 0, "vhead skips to tail", int'(o_vh[0]), 3);
      chk("R7", 1, "vhead stops at ready entry", int'(o_vh[1]), 2);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R9", 0, "retire issued head", int'(o_hd[0]), 1);
      cyc(0, 0, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R9", 1, "retire of unissued head ignored", int'(o_hd[1]), 2);
      chk("R9", 0, "retire issued head again", int'(o_hd[0]), 3);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R1", 0, "flush head", int'(o_hd[0]), 0);
      chk("R1", 0, "flush tail", int'(o_tl[0]), 0);
      chk("R1", 0, "flush vhead", int'(o_vh[0]), 0);
      chk("R1", 1, "flush sel_valid", int'(o_sv[1]), 0);
      for (int n = 0; n < 9; n++) cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R2", 0, "full queue ignores alloc", int'(o_tl[0]), 8);
      cyc(0, 0, 0, 0, 0, 0, 1);

      for (int n = 0; n < 3000; n++) begin
         bit hv;
         hv = (n / 500) % 2 == 1;
         cyc(($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
             int'($urandom % 8), ($urandom % 4) != 0,
             hv ? (($urandom % 3) != 0) : (($urandom % 3) == 0),
             ($urandom % 97) == 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule